// File: doc/BRIEF.md
# Split Page-Size Translation Cache

The block is a small, fully associative cache of virtual-to-physical address translations. It holds two separate arrays: a 64-entry array for 4 KiB pages and an 8-entry array for 2 MiB pages. A lookup presents a 48-bit virtual address. Both arrays are compared in the same cycle. In the following cycle the block returns hit or miss, the physical address and a flag that gives the page size.

A lookup that misses in both arrays moves the controller from state `ST_READY` to state `ST_WALK` (transition MISS). In `ST_WALK` the block raises a walk request and holds the missing address for an external table walker. Further lookups are refused until the walker answers on the fill port (transition FILL_RETURN, back to `ST_READY`).

The fill port accepts a translation in any cycle. It writes the translation into the array chosen by its page-size flag. Each array replaces its least recently used entry when it has no free entry. A single invalidate input empties both arrays at once.

Top module: `xlat_cache`

## Requirements
- R1: After reset both arrays are empty and `lk_ready` is 1. `walk_req` and `rsp_valid` are 0.
- R2: A lookup accepted in cycle t gives `rsp_valid`=1 in cycle t+1. On a 4 KiB hit, `rsp_hit`=1, `rsp_huge`=0, and `rsp_paddr` is the cached 36-bit frame followed by virtual bits 11-0.
- R3: The 2 MiB array matches on virtual bits 47-21. On a hit there, `rsp_huge`=1 and `rsp_paddr` is the cached 27-bit frame followed by virtual bits 20-0.
- R4: Both arrays are probed in the same cycle. When both hit, the 4 KiB entry is the one reported.
- R5: A miss in both arrays gives `rsp_hit`=0. From the next cycle the block raises `walk_req` with `walk_vaddr` equal to the missing address and holds `lk_ready` low until a fill arrives.
- R6: A fill with `fill_huge`=0 installs into the 4 KiB array and a fill with `fill_huge`=1 into the 2 MiB array. The frame is taken from the upper bits of `fill_paddr`. A fill while `walk_req` is high returns the block to ready.
- R7: A fill writes the lowest-index free entry of its array, or the least recently used entry when the array is full. The written entry becomes most recently used.
- R8: A lookup hit updates the recency order only in the array that supplies the response.
- R9: `inval_all` empties both arrays in one cycle. A lookup in the same cycle still sees the old contents, and any later lookup misses.
- R10: A fill that coincides with `inval_all` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Lookup virtual address |
| lk_ready | output | 1 | Lookups accepted (state `ST_READY`) |
| rsp_valid | output | 1 | Response valid, one cycle after an accepted lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_huge | output | 1 | Hit came from the 2 MiB array |
| rsp_paddr | output | 48 | Translated physical address |
| walk_req | output | 1 | Table walk requested (state `ST_WALK`) |
| walk_vaddr | output | 48 | Address that missed |
| fill_valid | input | 1 | Fill from walker |
| fill_huge | input | 1 | Fill page size: 1 for 2 MiB, 0 for 4 KiB |
| fill_vaddr | input | 48 | Virtual address of the filled page |
| fill_paddr | input | 48 | Physical address of the filled page |
| inval_all | input | 1 | Invalidate every entry |

## Verification
Two collisions matter. An invalidate can land in the same cycle as a fill, and a lookup can land in the same cycle as an invalidate. The bench provokes the first while a walk is pending: it raises `inval_all` and `fill_valid` together, then looks up the same address and requires a miss. It provokes the second by issuing a lookup together with `inval_all` on a cached page; that lookup must hit, and the lookup after it must miss. Random traffic over page pools larger than either array, with occasional invalidates, is compared against a recency-stamp model kept in the bench.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_WALK  = 1'b1
    } xlat_state_e;
endpackage

// File: rtl/xlat_lru.sv
module xlat_lru #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    input  logic [N-1:0]  valid,
    output logic [IW-1:0] victim_idx
);
    // age 0 = most recent, N-1 = least recent; ages form a permutation
    logic [IW-1:0] age [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age[i] <= IW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    age[i] <= '0;
                else if (age[i] < age[touch_idx])
                    age[i] <= age[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !found) begin
                victim_idx = IW'(i);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < N; i++) begin
                if (age[i] == IW'(N - 1)) victim_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/xlat_way_set.sv
module xlat_way_set #(
    parameter int N     = 8,
    parameter int TAG_W = 27,
    parameter int FRM_W = 27,
    parameter int IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inval,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic [FRM_W-1:0] hit_frame,
    input  logic             touch_hit,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [FRM_W-1:0] fill_frame
);
    logic [N-1:0]     valid;
    logic [TAG_W-1:0] tags   [N];
    logic [FRM_W-1:0] frames [N];
    logic [N-1:0]     match;
    logic [IW-1:0]    hit_idx;
    logic [IW-1:0]    victim;
    logic             fill_ok;
    logic             touch_en;
    logic [IW-1:0]    touch_idx;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == look_tag);
    end

    always_comb begin
        hit       = 1'b0;
        hit_idx   = '0;
        hit_frame = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit       = 1'b1;
                hit_idx   = IW'(i);
                hit_frame = frames[i];
            end
        end
    end

    // a fill outranks a hit for the recency update; invalidate kills fill
    assign fill_ok   = fill_en && !inval;
    assign touch_en  = fill_ok || (touch_hit && hit);
    assign touch_idx = fill_ok ? victim : hit_idx;

    xlat_lru #(.N(N), .IW(IW)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .valid      (valid),
        .victim_idx (victim)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            valid <= '0;
        else if (inval)
            valid <= '0;
        else if (fill_ok)
            valid[victim] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (fill_ok) begin
            tags[victim]   <= fill_tag;
            frames[victim] <= fill_frame;
        end
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int VA_W     = 48,
    parameter int PA_W     = 48,
    parameter int SMALL_N  = 64,
    parameter int HUGE_N   = 8,
    parameter int SMALL_SH = 12,
    parameter int HUGE_SH  = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [VA_W-1:0] lk_vaddr,
    output logic            lk_ready,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic            rsp_huge,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            walk_req,
    output logic [VA_W-1:0] walk_vaddr,
    input  logic            fill_valid,
    input  logic            fill_huge,
    input  logic [VA_W-1:0] fill_vaddr,
    input  logic [PA_W-1:0] fill_paddr,
    input  logic            inval_all
);
    localparam int ST_W = VA_W - SMALL_SH;
    localparam int HT_W = VA_W - HUGE_SH;
    localparam int SF_W = PA_W - SMALL_SH;
    localparam int HF_W = PA_W - HUGE_SH;

    xlat_state_e state, nxt;
    logic            accept;
    logic            s_hit, h_hit;
    logic [SF_W-1:0] s_frame;
    logic [HF_W-1:0] h_frame;
    logic            miss;

    assign accept = lk_valid && (state == ST_READY);
    assign miss   = !s_hit && !h_hit;

    xlat_way_set #(.N(SMALL_N), .TAG_W(ST_W), .FRM_W(SF_W)) u_small (
        .clk        (clk),
        .rst_n      (rst_n),
        .inval      (inval_all),
        .look_tag   (lk_vaddr[VA_W-1:SMALL_SH]),
        .hit        (s_hit),
        .hit_frame  (s_frame),
        .touch_hit  (accept),
        .fill_en    (fill_valid && !fill_huge),
        .fill_tag   (fill_vaddr[VA_W-1:SMALL_SH]),
        .fill_frame (fill_paddr[PA_W-1:SMALL_SH])
    );

    xlat_way_set #(.N(HUGE_N), .TAG_W(HT_W), .FRM_W(HF_W)) u_huge (
        .clk        (clk),
        .rst_n      (rst_n),
        .inval      (inval_all),
        .look_tag   (lk_vaddr[VA_W-1:HUGE_SH]),
        .hit        (h_hit),
        .hit_frame  (h_frame),
        .touch_hit  (accept && !s_hit),
        .fill_en    (fill_valid && fill_huge),
        .fill_tag   (fill_vaddr[VA_W-1:HUGE_SH]),
        .fill_frame (fill_paddr[PA_W-1:HUGE_SH])
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READY;
        else        state <= nxt;
    end

    // next state: MISS (READY->WALK), FILL_RETURN (WALK->READY)
    always_comb begin
        nxt = state;
        unique case (state)
            ST_READY: if (accept && miss) nxt = ST_WALK;
            ST_WALK:  if (fill_valid)     nxt = ST_READY;
            default:  nxt = ST_READY;
        endcase
    end

    assign lk_ready = (state == ST_READY);
    assign walk_req = (state == ST_WALK);

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_huge   <= 1'b0;
            rsp_paddr  <= '0;
            walk_vaddr <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_hit  <= !miss;
                rsp_huge <= !s_hit && h_hit;
                if (s_hit)
                    rsp_paddr <= {s_frame, lk_vaddr[SMALL_SH-1:0]};
                else if (h_hit)
                    rsp_paddr <= {h_frame, lk_vaddr[HUGE_SH-1:0]};
                else
                    rsp_paddr <= '0;
                if (miss) walk_vaddr <= lk_vaddr;
            end
        end
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int VA_W     = 48,
    parameter int PA_W     = 48,
    parameter int SMALL_SH = 12,
    parameter int HUGE_SH  = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            lk_ready,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_huge,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            walk_req,
    input logic [VA_W-1:0] walk_vaddr,
    input logic            fill_valid,
    input logic            inval_all
);
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rsp_valid); // R2

    AST_SMALL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && !rsp_huge) |->
            rsp_paddr[SMALL_SH-1:0] == $past(lk_vaddr[SMALL_SH-1:0])); // R2

    AST_HUGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && rsp_huge) |->
            rsp_paddr[HUGE_SH-1:0] == $past(lk_vaddr[HUGE_SH-1:0])); // R3

    AST_MISS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |->
            (walk_req && walk_vaddr == $past(lk_vaddr))); // R5

    AST_WALK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !lk_ready); // R5

    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !fill_valid) |=> (walk_req && $stable(walk_vaddr))); // R5

    AST_FILL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && fill_valid) |=> lk_ready); // R6

    AST_INVAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all ##1 (lk_valid && lk_ready) |=> (rsp_valid && !rsp_hit)); // R9
endmodule

bind xlat_cache xlat_cache_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .SMALL_SH(SMALL_SH), .HUGE_SH(HUGE_SH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_vaddr   (lk_vaddr),
    .lk_ready   (lk_ready),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_huge   (rsp_huge),
    .rsp_paddr  (rsp_paddr),
    .walk_req   (walk_req),
    .walk_vaddr (walk_vaddr),
    .fill_valid (fill_valid),
    .inval_all  (inval_all)
);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
    localparam int CLK_PERIOD = 10;
    localparam int SN = 64;
    localparam int HN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_vaddr = '0;
    logic        lk_ready, rsp_valid, rsp_hit, rsp_huge, walk_req;
    logic [47:0] rsp_paddr, walk_vaddr;
    logic        fill_valid = 1'b0;
    logic        fill_huge = 1'b0;
    logic [47:0] fill_vaddr = '0;
    logic [47:0] fill_paddr = '0;
    logic        inval_all = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_cache u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_huge(rsp_huge), .rsp_paddr(rsp_paddr), .walk_req(walk_req),
        .walk_vaddr(walk_vaddr), .fill_valid(fill_valid), .fill_huge(fill_huge),
        .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr), .inval_all(inval_all)
    );

    // bench model: recency stamps, larger stamp = more recent
    bit          ms_v [SN];
    logic [35:0] ms_t [SN];
    int          ms_s [SN];
    bit          mh_v [HN];
    logic [26:0] mh_t [HN];
    int          mh_s [HN];
    int          stamp = 1;

    function automatic logic [35:0] sfrm(input logic [35:0] vpn);
        return vpn ^ 36'h9_A5C3_0F1E;
    endfunction
    function automatic logic [26:0] hfrm(input logic [26:0] vpn);
        return vpn ^ 27'h5A5_3C3C;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < SN; i++) ms_v[i] = 1'b0;
        for (int i = 0; i < HN; i++) mh_v[i] = 1'b0;
    endtask

    task automatic model_fill(input logic [47:0] va, input bit huge);
        int v; int best;
        v = -1;
        if (!huge) begin
            for (int i = 0; i < SN; i++) if (!ms_v[i] && v < 0) v = i;
            if (v < 0) begin
                best = 32'h7fffffff;
                for (int i = 0; i < SN; i++) if (ms_s[i] < best) begin best = ms_s[i]; v = i; end
            end
            ms_v[v] = 1'b1; ms_t[v] = va[47:12]; ms_s[v] = stamp++;
        end else begin
            for (int i = 0; i < HN; i++) if (!mh_v[i] && v < 0) v = i;
            if (v < 0) begin
                best = 32'h7fffffff;
                for (int i = 0; i < HN; i++) if (mh_s[i] < best) begin best = mh_s[i]; v = i; end
            end
            mh_v[v] = 1'b1; mh_t[v] = va[47:21]; mh_s[v] = stamp++;
        end
    endtask

    // drive a fill starting at a falling edge, return at the next one
    task automatic do_fill(input logic [47:0] va, input bit huge, input bit with_inval);
        fill_valid = 1'b1; fill_huge = huge; fill_vaddr = va;
        fill_paddr = huge ? {hfrm(va[47:21]), 21'h0} : {sfrm(va[47:12]), 12'h0};
        inval_all = with_inval;
        @(negedge clk);
        fill_valid = 1'b0; inval_all = 1'b0;
        if (with_inval) model_clear();
        else model_fill(va, huge);
    endtask

    bit last_hit;

    // lookup checked against the model; optional invalidate in the same cycle
    task automatic do_look(input logic [47:0] va, input string rq, input bit with_inval);
        bit eh; bit ehuge; logic [47:0] epa; int si; int hi;
        si = -1; hi = -1;
        for (int i = 0; i < SN; i++) if (ms_v[i] && ms_t[i] == va[47:12] && si < 0) si = i;
        for (int i = 0; i < HN; i++) if (mh_v[i] && mh_t[i] == va[47:21] && hi < 0) hi = i;
        eh = (si >= 0) || (hi >= 0);
        ehuge = (si < 0) && (hi >= 0);
        epa = (si >= 0) ? {sfrm(va[47:12]), va[11:0]} :
              (hi >= 0) ? {hfrm(va[47:21]), va[20:0]} : 48'h0;
        if (si >= 0) ms_s[si] = stamp++;
        else if (hi >= 0) mh_s[hi] = stamp++;
        chk(lk_ready == 1'b1, {rq, " ready before lookup"}, 48'(lk_ready), 48'h1);
        lk_valid = 1'b1; lk_vaddr = va; inval_all = with_inval;
        @(negedge clk);
        lk_valid = 1'b0; inval_all = 1'b0;
        if (with_inval) model_clear();
        chk(rsp_valid == 1'b1, {rq, " rsp_valid"}, 48'(rsp_valid), 48'h1);
        chk(rsp_hit == eh, {rq, " rsp_hit"}, 48'(rsp_hit), 48'(eh));
        if (eh) begin
            chk(rsp_huge == ehuge, {rq, " rsp_huge"}, 48'(rsp_huge), 48'(ehuge));
            chk(rsp_paddr == epa, {rq, " rsp_paddr"}, rsp_paddr, epa);
        end else begin
            chk(walk_req == 1'b1 && lk_ready == 1'b0, {rq, " R5 walk_req"}, 48'(walk_req), 48'h1);
            chk(walk_vaddr == va, {rq, " R5 walk_vaddr"}, walk_vaddr, va);
        end
        last_hit = rsp_hit;
    endtask

    function automatic logic [47:0] sva(input int idx, input logic [11:0] off);
        return 48'h0000_1000_0000 + 48'(idx) * 48'h1000 + 48'(off);
    endfunction
    function automatic logic [47:0] hva(input int idx, input logic [20:0] off);
        return 48'h4000_0000_0000 + 48'(idx) * 48'h20_0000 + 48'(off);
    endfunction

    initial begin
        void'($urandom(32'd5150));
        model_clear();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(lk_ready == 1'b1 && walk_req == 1'b0 && rsp_valid == 1'b0, "R1 reset outputs",
            {45'h0, lk_ready, walk_req, rsp_valid}, 48'h4);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R6 R2: small miss, fill, hit
        do_look(sva(3, 12'h7AB), "R5 small miss", 1'b0);
        chk(last_hit == 1'b0, "R1 empty after reset", 48'(last_hit), 48'h0);
        do_fill(sva(3, 12'h0), 1'b0, 1'b0);
        chk(lk_ready == 1'b1, "R6 fill returns ready", 48'(lk_ready), 48'h1);
        do_look(sva(3, 12'hFFF), "R2 small hit", 1'b0);
        chk(last_hit == 1'b1, "R2 hit after fill", 48'(last_hit), 48'h1);

        // R3: huge miss, fill, hit with wide offset
        do_look(hva(1, 21'h1F_FFF0), "R5 huge miss", 1'b0);
        do_fill(hva(1, 21'h0), 1'b1, 1'b0);
        do_look(hva(1, 21'h15_4321), "R3 huge hit", 1'b0);
        chk(rsp_huge == 1'b1, "R3 huge flag", 48'(rsp_huge), 48'h1);

        // R4: small entry inside a cached huge page wins
        do_fill(hva(1, 21'h3000), 1'b0, 1'b0);
        do_look(hva(1, 21'h3456), "R4 both hit", 1'b0);
        chk(rsp_huge == 1'b0, "R4 small preferred", 48'(rsp_huge), 48'h0);

        // R7 R8: huge array recency not touched by small hits
        do_fill(48'h0, 1'b0, 1'b1);
        for (int i = 0; i < HN; i++) do_fill(hva(10 + i, 21'h0), 1'b1, 1'b0);
        do_fill(hva(11, 21'h5000), 1'b0, 1'b0);
        do_look(hva(10, 21'h77), "R8 touch huge0", 1'b0);
        do_look(hva(11, 21'h5123), "R8 small hit in huge1 page", 1'b0);
        chk(rsp_huge == 1'b0, "R8 small supplied", 48'(rsp_huge), 48'h0);
        do_fill(hva(30, 21'h0), 1'b1, 1'b0);
        do_look(hva(11, 21'h9999), "R8 huge1 evicted", 1'b0);
        chk(last_hit == 1'b0, "R8 huge1 was LRU", 48'(last_hit), 48'h0);
        do_fill(hva(11, 21'h0), 1'b1, 1'b0);
        do_look(hva(10, 21'h1), "R7 huge0 kept", 1'b0);
        chk(last_hit == 1'b1, "R7 recent entry kept", 48'(last_hit), 48'h1);

        // R7: small array LRU victim
        do_fill(48'h0, 1'b0, 1'b1);
        for (int i = 0; i < SN; i++) do_fill(sva(100 + i, 12'h0), 1'b0, 1'b0);
        do_look(sva(100, 12'h1), "R7 touch small0", 1'b0);
        do_fill(sva(500, 12'h0), 1'b0, 1'b0);
        do_look(sva(101, 12'h2), "R7 small1 evicted", 1'b0);
        chk(last_hit == 1'b0, "R7 small LRU replaced", 48'(last_hit), 48'h0);
        do_fill(sva(101, 12'h0), 1'b0, 1'b0);
        do_look(sva(100, 12'h3), "R7 small0 kept", 1'b0);
        chk(last_hit == 1'b1, "R7 small0 hit", 48'(last_hit), 48'h1);

        // R9: lookup coinciding with invalidate sees old contents
        do_look(sva(100, 12'h4), "R9 same-cycle lookup", 1'b1);
        chk(last_hit == 1'b1, "R9 old contents", 48'(last_hit), 48'h1);
        do_look(sva(100, 12'h5), "R9 after invalidate", 1'b0);
        chk(last_hit == 1'b0, "R9 emptied", 48'(last_hit), 48'h0);

        // R10: fill colliding with invalidate is dropped
        do_fill(sva(100, 12'h0), 1'b0, 1'b1);
        chk(lk_ready == 1'b1, "R10 walk released", 48'(lk_ready), 48'h1);
        do_look(sva(100, 12'h6), "R10 dropped fill", 1'b0);
        chk(last_hit == 1'b0, "R10 still miss", 48'(last_hit), 48'h0);
        do_fill(sva(100, 12'h0), 1'b0, 1'b0);

        // random traffic over pools larger than the arrays
        for (int n = 0; n < 1500; n++) begin
            int r;
            logic [47:0] va;
            bit huge;
            r = int'($urandom_range(0, 99));
            if (r < 3) begin
                do_fill(48'h0, 1'b0, 1'b1);
            end else begin
                huge = (r < 25);
                va = huge ? hva(int'($urandom_range(0, 11)), 21'($urandom))
                          : sva(int'($urandom_range(0, 89)), 12'($urandom));
                do_look(va, "R7 R2 R3 random", 1'b0);
                if (!last_hit) do_fill(va, huge, 1'b0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule